// File: doc/BRIEF.md
# Converter Hold, Power-Down and Channel Sequencer

This block sits beside a delta-sigma converter's decimation filter and decides when the modulator runs, when the filter restarts and when a conversion result may be announced. It splits the system clock into conversion frames of `FRAME_LEN` cycles. At each frame end it samples the level of the serial clock line. If the line is high for several frame ends in a row, the modulator is held in reset so that several converters can be aligned. If the line stays high longer, the converter is powered down. Both states end when the line falls.

The block also samples a channel select code on the falling edge of the system clock. A new code restarts the conversion. Ready indications stay suppressed until the filter has seen `SETTLE_FRAMES` complete frames of the new input. The outputs drive the modulator reset, a one-cycle filter restart, the power-down enable, the channel index and two overrides for the ready pin. One override forces a short low pulse. The other holds the pin high.

Top module: `conv_ctl_seq`

## Requirements
- R1: While reset is asserted, the outputs are as follows: `mod_rst_o`, `filt_restart_o`, `pwr_down_o`, `data_valid_o` and `rdy_low_o` are 0, `rdy_high_o` is 1 and `chan_o` is 0.
- R2: The frame counter is restarted by reset release, a channel change or a hold release. Take the first rising edge after that restart as edge E. `data_valid_o` then pulses for one cycle in the cycle after edge E+5*FRAME_LEN-1, and again every FRAME_LEN cycles. `rdy_high_o` stays 1 until the first of these pulses.
- R3: When `sclk_i` is seen high at 4 consecutive frame ends, `mod_rst_o` rises at the edge that follows the fourth one. `rdy_low_o` is 1 for exactly 3 cycles starting in that cycle. After those 3 cycles, `rdy_high_o` is 1 for as long as the hold lasts.
- R4: When `sclk_i` is seen low at any frame end, the count of high frame ends returns to zero. A partial hold therefore does not add to a later one.
- R5: When `sclk_i` is seen high at 20 consecutive frame ends, `pwr_down_o` rises at the edge that follows the twentieth. It stays high, together with `mod_rst_o`, until release. The frame counter stalls while it is high.
- R6: While `mod_rst_o` is high, a falling `sclk_i` clears `mod_rst_o` and `pwr_down_o` at the next rising edge. At the same edge `filt_restart_o` goes high for one cycle and settling starts again as in R2.
- R7: A falling `sclk_i` while `mod_rst_o` is low produces no restart.
- R8: `chsel_i` is sampled on the falling system clock edge. A new code appears on `chan_o` at the next rising edge, together with a one-cycle `filt_restart_o`. Codes 00, 01, 10 and 11 select the first to fourth input.
- R9: `data_valid_o` is never high while `mod_rst_o` or `pwr_down_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock level, already synchronised |
| chsel_i | input | CH_W | Channel select code |
| mod_rst_o | output | 1 | Hold the modulator in reset |
| filt_restart_o | output | 1 | One-cycle filter restart |
| pwr_down_o | output | 1 | Power-down enable |
| chan_o | output | CH_W | Active channel index |
| data_valid_o | output | 1 | Settled result completed this cycle |
| rdy_low_o | output | 1 | Force the ready pin low |
| rdy_high_o | output | 1 | Hold the ready pin high |

## Verification
Every result has a fixed latency counted in rising edges. A restart is visible one cycle after the release or change that causes it. A channel code appears on the rising edge after the falling edge that sampled it. The hold states change one edge after the deciding frame end. The first valid pulse falls 5*FRAME_LEN-1 cycles after a restart. The bench keeps a free-running edge counter. It drives inputs 1 ns after a rising edge and samples on the falling edge. Before each phase it queues every event it expects, stamped with its edge number. The monitor pops and compares each event as it occurs, so a late, early, missing or extra event is reported.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    HOLD_IDLE  = 2'd0,
    HOLD_SYNC  = 2'd1,
    HOLD_PDOWN = 2'd2
  } hold_state_e;

  function automatic int unsigned cnt_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/conv_frame_timer.sv
module conv_frame_timer #(
  parameter int unsigned FRAME_LEN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic stall_i,
  output logic tick_o
);
  localparam int unsigned FW = conv_seq_pkg::cnt_w(FRAME_LEN - 1);
  localparam logic [FW-1:0] LAST = FW'(FRAME_LEN - 1);

  logic [FW-1:0] fcnt_q;

  assign tick_o = (fcnt_q == LAST) && !stall_i && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fcnt_q <= '0;
    else if (restart_i) fcnt_q <= '0;
    else if (!stall_i)  fcnt_q <= (fcnt_q == LAST) ? '0 : fcnt_q + 1'b1;
  end
endmodule

// File: rtl/conv_hold_tracker.sv
module conv_hold_tracker
  import conv_seq_pkg::*;
#(
  parameter int unsigned SYNC_FRAMES = 4,
  parameter int unsigned PD_FRAMES   = 20,
  parameter int unsigned PULSE_LEN   = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sclk_i,
  input  logic        tick_i,
  output hold_state_e state_o,
  output logic        release_o,
  output logic        force_low_o
);
  localparam int unsigned HW = cnt_w(PD_FRAMES);
  localparam int unsigned PW = cnt_w(PULSE_LEN);
  localparam logic [HW-1:0] H_SYNC = HW'(SYNC_FRAMES);
  localparam logic [HW-1:0] H_PD   = HW'(PD_FRAMES);

  logic [HW-1:0] hcnt_q;
  logic [PW-1:0] plen_q;
  logic          sclk_q;
  logic          active;

  assign active      = (hcnt_q >= H_SYNC);
  assign release_o   = active && sclk_q && !sclk_i;
  assign force_low_o = (plen_q != '0);

  always_comb begin
    if (hcnt_q >= H_PD)  state_o = HOLD_PDOWN;
    else if (active)     state_o = HOLD_SYNC;
    else                 state_o = HOLD_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      hcnt_q <= '0;
      plen_q <= '0;
    end else begin
      sclk_q <= sclk_i;
      if (release_o) begin
        hcnt_q <= '0;
        plen_q <= '0;
      end else begin
        if (tick_i) begin
          if (!sclk_i)            hcnt_q <= '0;
          else if (hcnt_q != H_PD) hcnt_q <= hcnt_q + 1'b1;
        end
        if (tick_i && sclk_i && (hcnt_q == H_SYNC - 1'b1)) plen_q <= PW'(PULSE_LEN);
        else if (plen_q != '0)                             plen_q <= plen_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/conv_settle_tracker.sv
module conv_settle_tracker #(
  parameter int unsigned CH_W          = 2,
  parameter int unsigned SETTLE_FRAMES = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CH_W-1:0] chsel_i,
  input  logic            tick_i,
  input  logic            clear_i,
  input  logic            hold_i,
  output logic [CH_W-1:0] chan_o,
  output logic            change_o,
  output logic            valid_o,
  output logic            unsettled_o
);
  localparam int unsigned SW = conv_seq_pkg::cnt_w(SETTLE_FRAMES);
  localparam logic [SW-1:0] S_DONE = SW'(SETTLE_FRAMES);

  logic [CH_W-1:0] chsel_n_q;
  logic [CH_W-1:0] chan_q;
  logic [SW-1:0]   scnt_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chsel_n_q <= '0;
    else         chsel_n_q <= chsel_i;
  end

  assign change_o    = (chsel_n_q != chan_q);
  assign chan_o      = chan_q;
  assign valid_o     = tick_i && (scnt_q >= S_DONE - 1'b1) && !hold_i && !clear_i && !change_o;
  assign unsettled_o = (scnt_q < S_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= '0;
      scnt_q <= '0;
    end else begin
      chan_q <= chsel_n_q;
      if (change_o || clear_i || hold_i)   scnt_q <= '0;
      else if (tick_i && scnt_q != S_DONE) scnt_q <= scnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/conv_ctl_seq.sv
module conv_ctl_seq
  import conv_seq_pkg::*;
#(
  parameter int unsigned FRAME_LEN     = 64,
  parameter int unsigned N_CH          = 4,
  parameter int unsigned SYNC_FRAMES   = 4,
  parameter int unsigned PD_FRAMES     = 20,
  parameter int unsigned PULSE_LEN     = 3,
  parameter int unsigned SETTLE_FRAMES = 5,
  localparam int unsigned CH_W         = $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sclk_i,
  input  logic [CH_W-1:0] chsel_i,
  output logic            mod_rst_o,
  output logic            filt_restart_o,
  output logic            pwr_down_o,
  output logic [CH_W-1:0] chan_o,
  output logic            data_valid_o,
  output logic            rdy_low_o,
  output logic            rdy_high_o
);
  hold_state_e state;
  logic tick, release_hold, force_low, change, unsettled, restart, restart_q, held;

  assign held    = (state != HOLD_IDLE);
  assign restart = change || release_hold;

  conv_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_frame (
    .clk_i, .rst_ni,
    .restart_i (restart),
    .stall_i   (state == HOLD_PDOWN),
    .tick_o    (tick)
  );

  conv_hold_tracker #(
    .SYNC_FRAMES(SYNC_FRAMES), .PD_FRAMES(PD_FRAMES), .PULSE_LEN(PULSE_LEN)
  ) u_hold (
    .clk_i, .rst_ni,
    .sclk_i,
    .tick_i      (tick),
    .state_o     (state),
    .release_o   (release_hold),
    .force_low_o (force_low)
  );

  conv_settle_tracker #(.CH_W(CH_W), .SETTLE_FRAMES(SETTLE_FRAMES)) u_settle (
    .clk_i, .rst_ni,
    .chsel_i,
    .tick_i      (tick),
    .clear_i     (release_hold),
    .hold_i      (held),
    .chan_o      (chan_o),
    .change_o    (change),
    .valid_o     (data_valid_o),
    .unsettled_o (unsettled)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) restart_q <= 1'b0;
    else         restart_q <= restart;
  end

  assign filt_restart_o = restart_q;
  assign mod_rst_o      = held;
  assign pwr_down_o     = (state == HOLD_PDOWN);
  assign rdy_low_o      = force_low;
  assign rdy_high_o     = !force_low && !data_valid_o && (held || unsettled);
endmodule

// File: rtl/conv_ctl_seq_chk.sv
module conv_ctl_seq_chk #(
  parameter int unsigned CH_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sclk_i,
  input logic            mod_rst_o,
  input logic            filt_restart_o,
  input logic            pwr_down_o,
  input logic [CH_W-1:0] chan_o,
  input logic            data_valid_o,
  input logic            rdy_low_o,
  input logic            rdy_high_o
);
  // R3
  pulse_on_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod_rst_o) |-> rdy_low_o);
  // R3
  pulse_inside_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_low_o |-> mod_rst_o && !rdy_high_o);
  // R9
  no_valid_in_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> !mod_rst_o && !pwr_down_o);
  // R6
  release_restarts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mod_rst_o) |-> filt_restart_o && !sclk_i);
  // R8
  chan_change_restarts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chan_o) |-> filt_restart_o);
  // R2
  restart_not_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_restart_o |-> !data_valid_o);
  // R5
  pdown_after_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_down_o) |-> $past(mod_rst_o));
endmodule

bind conv_ctl_seq conv_ctl_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .mod_rst_o(mod_rst_o),
  .filt_restart_o(filt_restart_o), .pwr_down_o(pwr_down_o), .chan_o(chan_o),
  .data_valid_o(data_valid_o), .rdy_low_o(rdy_low_o), .rdy_high_o(rdy_high_o)
);

// File: tb/conv_ctl_seq_bench.sv
`timescale 1ns/1ps
module conv_ctl_seq_bench;
  localparam int FL = 8;
  localparam int EV_RST = 0, EV_VAL = 1, EV_PLS = 2, EV_PD = 3;

  typedef struct {
    int    kind;
    int    cyc;
    string req;
  } ev_t;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0;
  logic [1:0] chsel = 2'd0;
  logic mod_rst, filt_rst, pwr_down, valid, rdy_low, rdy_high;
  logic [1:0] chan;
  int cyc = 0;
  int checks = 0, errors = 0;
  ev_t exp_q[$];
  logic low_prev = 1'b0, pd_prev = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  conv_ctl_seq #(.FRAME_LEN(FL)) u_conv_ctl_seq (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .chsel_i(chsel),
    .mod_rst_o(mod_rst), .filt_restart_o(filt_rst), .pwr_down_o(pwr_down),
    .chan_o(chan), .data_valid_o(valid), .rdy_low_o(rdy_low), .rdy_high_o(rdy_high)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic push(input int kind, input int c, input string req);
    ev_t e;
    e.kind = kind; e.cyc = c; e.req = req;
    exp_q.push_back(e);
  endtask

  // R2: first valid at E+5*FL-1, then every FL
  task automatic push_valids(input int e_cyc, input int n, input string req);
    for (int i = 0; i < n; i++) push(EV_VAL, e_cyc + 5*FL - 1 + i*FL, req);
  endtask

  task automatic observe(input int kind);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk("unexpected event", kind, -1);
    end else begin
      e = exp_q.pop_front();
      chk({e.req, " event kind"}, kind, e.kind);
      chk({e.req, " event cycle"}, cyc, e.cyc);
    end
  endtask

  // monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (filt_rst)              observe(EV_RST);
      if (valid)                 observe(EV_VAL);
      if (rdy_low && !low_prev)  observe(EV_PLS);
      if (pwr_down && !pd_prev)  observe(EV_PD);
      low_prev = rdy_low;
      pd_prev  = pwr_down;
    end
  end

  task automatic to_cyc(input int n);
    while (cyc != n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic at_neg(input int n);
    to_cyc(n);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #10;
    chk("R1 mod_rst", mod_rst, 0);
    chk("R1 filt_restart", filt_rst, 0);
    chk("R1 pwr_down", pwr_down, 0);
    chk("R1 valid", valid, 0);
    chk("R1 rdy_low", rdy_low, 0);
    chk("R1 rdy_high", rdy_high, 1);
    chk("R1 chan", chan, 0);
    #12 rst_n = 1'b1;

    // settle from reset
    push_valids(0, 3, "R2");
    at_neg(20);  chk("R2 held high while settling", rdy_high, 1);
    at_neg(50);  chk("R2 released after settle", rdy_high, 0);

    // channel change to code 10
    push(EV_RST, 61, "R8");
    push_valids(61, 3, "R2");
    to_cyc(60); chsel = 2'd2;
    @(negedge clk); chk("R8 chan before rising edge", chan, 0);
    at_neg(61); chk("R8 chan code 10", chan, 2);
    at_neg(80); chk("R2 held high after change", rdy_high, 1);

    // sync hold and release
    for (int i = 0; i < 4; i++) push(EV_VAL, 124 + i*FL, "R2");
    push(EV_PLS, 149, "R3");
    push(EV_RST, 201, "R6");
    push_valids(201, 3, "R6");
    to_cyc(120); sclk = 1'b1;
    at_neg(148); chk("R3 no reset before 4th frame", mod_rst, 0);
    at_neg(150); chk("R3 mod_rst held", mod_rst, 1);
    chk("R3 pulse low", rdy_low, 1);
    at_neg(151); chk("R3 pulse third cycle", rdy_low, 1);
    at_neg(152); chk("R3 pulse ended", rdy_low, 0);
    chk("R3 held high after pulse", rdy_high, 1);
    at_neg(170); chk("R9 no power-down yet", pwr_down, 0);
    to_cyc(200); sclk = 1'b0;
    at_neg(201); chk("R6 mod_rst released", mod_rst, 0);

    // partial hold, then full hold into power-down
    for (int i = 0; i < 8; i++) push(EV_VAL, 264 + i*FL, "R4");
    push(EV_PLS, 321, "R4");
    push(EV_PD, 449, "R5");
    push(EV_RST, 471, "R6");
    push_valids(471, 3, "R6");
    to_cyc(260); sclk = 1'b1;
    to_cyc(282); sclk = 1'b0;
    at_neg(284); chk("R7 no restart on idle fall", filt_rst, 0);
    chk("R7 no reset on idle fall", mod_rst, 0);
    to_cyc(290); sclk = 1'b1;
    at_neg(318); chk("R4 count cleared", mod_rst, 0);
    at_neg(448); chk("R5 not yet powered down", pwr_down, 0);
    at_neg(460); chk("R5 powered down", pwr_down, 1);
    chk("R5 reset held in power-down", mod_rst, 1);
    chk("R5 no ready pulse", valid, 0);
    to_cyc(470); sclk = 1'b0;
    at_neg(471); chk("R6 power-down released", pwr_down, 0);
    chk("R6 reset released", mod_rst, 0);

    // channel code 11
    push(EV_RST, 531, "R8");
    push_valids(531, 1, "R8");
    to_cyc(530); chsel = 2'd3;
    at_neg(531); chk("R8 chan code 11", chan, 3);
    at_neg(575);
    chk("R2 all expected events seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule